// File: doc/BRIEF.md
# Iterative Lane-to-Pipe Matcher

This block pairs up to L front-end instruction lanes with P back-end issue pipes in every cycle. No lane gets more than one pipe and no pipe gets more than one lane. The matching is built by rounds of grant and accept, in the manner of iSLIP, and all rounds are unrolled into combinational logic. The result is ready in the same cycle as the inputs, so the decode stage can route the instruction bundle that it is currently holding.

Each round works on the lanes and pipes that are still free. First, every free pipe grants to the oldest lane that is eligible for it. Age is measured by sequence numbers taken relative to the oldest committed sequence number, so the ordering stays correct when the sequence counter wraps. Then every lane that received grants accepts one of them: the pipe whose queue reports the most open slots. Accepted pairs leave the free masks before the next round starts. The matches from all rounds are merged into per-pipe outputs (a valid bit and a lane index) and per-lane outputs (a hit flag and a pipe index).

Since the block is purely combinational it has no state register. Its named phases are ELIGIBLE (the pair filter), GRANT, ACCEPT and RETIRE (removal from the free masks). The phases run in that order once per round, and there are ITERS rounds.

Top module: `lane_pipe_matcher`

## Requirements
- R1: Pair (l, p) is eligible only when all four conditions hold: compat_i[l*P+p]=1, lane_valid_i[l]=1, q_ready_i[p]=1 and q_slots_i for p is nonzero. An ineligible pair is never matched.
- R2: When pipe_bypass_i[p]=1, pipe p may be matched to lane l only if src_a_rdy_i[l]=1 and src_b_rdy_i[l]=1.
- R3: In each round, every free pipe grants to the free eligible lane that is oldest. Lane j is older than lane i when (seq[j]<seq[i]) XOR (seq[j]<oldest) XOR (seq[i]<oldest), with unsigned compares against oldest_seq_i.
- R4: When two candidate lanes are equally old, the pipe grants to the lane with the lower index.
- R5: A lane holding one or more grants accepts the granting pipe with the largest q_slots_i value. On equal slot counts it accepts the lowest-indexed pipe.
- R6: A matched lane or pipe takes no part in later rounds. Later rounds can pair the remaining lanes and pipes, and the final matching is one-to-one.
- R7: The round count ITERS defaults to L. With ITERS >= min(L, P), no eligible pair is left with both its lane and its pipe unmatched.
- R8: pipe_val_o[p]=1 with pipe_lane_o[p]=l holds exactly when lane_hit_o[l]=1 with lane_pipe_o[l]=p. Indices are packed as LIDX-bit fields per pipe and PIDX-bit fields per lane, with the field for index 0 in the least significant bits.
- R9: A lane with no match drives lane_hit_o=0, and a pipe with no match drives pipe_val_o=0. When no pair is eligible, every flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| compat_i | input | L*P | Operation support for each pair, bit l*P+p |
| lane_valid_i | input | L | Lane carries an instruction |
| lane_seq_i | input | L*SEQW | Sequence number of each lane |
| src_a_rdy_i | input | L | First source operand of the lane is ready |
| src_b_rdy_i | input | L | Second source operand of the lane is ready |
| q_ready_i | input | P | Issue queue of the pipe can accept |
| q_slots_i | input | P*SLOTW | Open slots in each pipe's queue |
| pipe_bypass_i | input | P | Pipe issues with no buffering |
| oldest_seq_i | input | SEQW | Oldest committed sequence number |
| pipe_val_o | output | P | Pipe received a lane |
| pipe_lane_o | output | P*LIDX | Index of the lane sent to each pipe |
| lane_hit_o | output | L | Lane was matched |
| lane_pipe_o | output | L*PIDX | Index of the pipe chosen for each lane |

## Verification
The bench stresses the following corner cases, with the wrong behaviour each one would expose:
- Wrap-around age, where a sequence number that is numerically larger is in fact older. A plain magnitude compare would hand the pipe to the younger lane.
- Ties on age and ties on slot count. A design with a reversed scan would pick the higher index.
- Conflicts that can only be resolved in a second round, because a lane's favourite pipe was taken first. A design that forgets to retire matched ports would assign the same pipe twice, and one with too few rounds would leave the pair unmatched.
- Each of the four eligibility conditions and the bypass operand rule, turned off one at a time. Dropping any one of them would show up as a spurious match.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Wrap-safe age test: is sequence a older than sequence b, relative to the oldest live number.
    function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b,
                                       input logic [31:0] oldest);
        return (a < b) ^ (a < oldest) ^ (b < oldest);
    endfunction

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lpm_elig.sv
module lpm_elig #(
    parameter int L     = 4,
    parameter int P     = 3,
    parameter int SLOTW = 4
) (
    input  logic [L*P-1:0]     compat_i,
    input  logic [L-1:0]       lane_valid_i,
    input  logic [L-1:0]       src_a_rdy_i,
    input  logic [L-1:0]       src_b_rdy_i,
    input  logic [P-1:0]       q_ready_i,
    input  logic [P*SLOTW-1:0] q_slots_i,
    input  logic [P-1:0]       pipe_bypass_i,
    output logic [L*P-1:0]     elig_o
);
    for (genvar l = 0; l < L; l++) begin : g_lane
        for (genvar p = 0; p < P; p++) begin : g_pipe
            logic has_room;
            logic ops_ok;
            assign has_room = |q_slots_i[p*SLOTW +: SLOTW];
            assign ops_ok   = !pipe_bypass_i[p] || (src_a_rdy_i[l] && src_b_rdy_i[l]);
            assign elig_o[l*P+p] = compat_i[l*P+p] && lane_valid_i[l] && q_ready_i[p]
                                   && has_room && ops_ok;
        end
    end
endmodule

// File: rtl/lpm_round.sv
module lpm_round
    import lpm_pkg::*;
#(
    parameter int L     = 4,
    parameter int P     = 3,
    parameter int SEQW  = 8,
    parameter int SLOTW = 4
) (
    input  logic [L*P-1:0]     elig_i,
    input  logic [L-1:0]       lane_free_i,
    input  logic [P-1:0]       pipe_free_i,
    input  logic [L*SEQW-1:0]  lane_seq_i,
    input  logic [SEQW-1:0]    oldest_seq_i,
    input  logic [P*SLOTW-1:0] q_slots_i,
    output logic [L*P-1:0]     match_o,
    output logic [L-1:0]       lane_free_o,
    output logic [P-1:0]       pipe_free_o
);
    logic [L*P-1:0] gnt;

    // GRANT: each free pipe picks its oldest free eligible lane; a strict test keeps ties on the lower lane.
    for (genvar p = 0; p < P; p++) begin : g_grant
        logic [L-1:0] pick;
        always_comb begin
            int  best;
            logic found;
            best  = 0;
            found = 1'b0;
            pick  = '0;
            for (int l = 0; l < L; l++) begin
                if (elig_i[l*P+p] && lane_free_i[l] && pipe_free_i[p]) begin
                    if (!found || seq_older(32'(lane_seq_i[l*SEQW +: SEQW]),
                                            32'(lane_seq_i[best*SEQW +: SEQW]),
                                            32'(oldest_seq_i))) begin
                        best  = l;
                        found = 1'b1;
                    end
                end
            end
            if (found) pick[best] = 1'b1;
        end
        for (genvar l = 0; l < L; l++) begin : g_col
            assign gnt[l*P+p] = pick[l];
        end
    end

    // ACCEPT: each lane takes the granting pipe with the most slots; a strict test keeps ties on the lower pipe.
    for (genvar l = 0; l < L; l++) begin : g_accept
        always_comb begin
            int   best;
            logic found;
            best  = 0;
            found = 1'b0;
            match_o[l*P +: P] = '0;
            for (int p = 0; p < P; p++) begin
                if (gnt[l*P+p]) begin
                    if (!found || (q_slots_i[p*SLOTW +: SLOTW] > q_slots_i[best*SLOTW +: SLOTW])) begin
                        best  = p;
                        found = 1'b1;
                    end
                end
            end
            if (found) match_o[l*P+best] = 1'b1;
        end

        always_comb begin
            assert_accept_single_R5: assert ($onehot0(match_o[l*P +: P]))
                else $error("lane accepted more than one pipe");
        end
    end

    // RETIRE: matched ports leave the free masks.
    always_comb begin
        lane_free_o = lane_free_i;
        pipe_free_o = pipe_free_i;
        for (int l = 0; l < L; l++) begin
            for (int p = 0; p < P; p++) begin
                if (match_o[l*P+p]) begin
                    lane_free_o[l] = 1'b0;
                    pipe_free_o[p] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/lane_pipe_matcher.sv
module lane_pipe_matcher
    import lpm_pkg::*;
#(
    parameter int L     = 4,
    parameter int P     = 3,
    parameter int SEQW  = 8,
    parameter int SLOTW = 4,
    parameter int ITERS = L,
    localparam int LIDX = idx_bits(L),
    localparam int PIDX = idx_bits(P)
) (
    input  logic [L*P-1:0]     compat_i,
    input  logic [L-1:0]       lane_valid_i,
    input  logic [L*SEQW-1:0]  lane_seq_i,
    input  logic [L-1:0]       src_a_rdy_i,
    input  logic [L-1:0]       src_b_rdy_i,
    input  logic [P-1:0]       q_ready_i,
    input  logic [P*SLOTW-1:0] q_slots_i,
    input  logic [P-1:0]       pipe_bypass_i,
    input  logic [SEQW-1:0]    oldest_seq_i,
    output logic [P-1:0]       pipe_val_o,
    output logic [P*LIDX-1:0]  pipe_lane_o,
    output logic [L-1:0]       lane_hit_o,
    output logic [L*PIDX-1:0]  lane_pipe_o
);
    localparam int MINLP = (L < P) ? L : P;

    logic [L*P-1:0] elig;
    logic [L-1:0]   lane_free [ITERS+1];
    logic [P-1:0]   pipe_free [ITERS+1];
    logic [L*P-1:0] match_acc [ITERS+1];

    lpm_elig #(.L(L), .P(P), .SLOTW(SLOTW)) i_elig (
        .compat_i     (compat_i),
        .lane_valid_i (lane_valid_i),
        .src_a_rdy_i  (src_a_rdy_i),
        .src_b_rdy_i  (src_b_rdy_i),
        .q_ready_i    (q_ready_i),
        .q_slots_i    (q_slots_i),
        .pipe_bypass_i(pipe_bypass_i),
        .elig_o       (elig)
    );

    assign lane_free[0] = '1;
    assign pipe_free[0] = '1;
    assign match_acc[0] = '0;

    for (genvar r = 0; r < ITERS; r++) begin : g_round
        logic [L*P-1:0] m;
        lpm_round #(.L(L), .P(P), .SEQW(SEQW), .SLOTW(SLOTW)) i_round (
            .elig_i      (elig),
            .lane_free_i (lane_free[r]),
            .pipe_free_i (pipe_free[r]),
            .lane_seq_i  (lane_seq_i),
            .oldest_seq_i(oldest_seq_i),
            .q_slots_i   (q_slots_i),
            .match_o     (m),
            .lane_free_o (lane_free[r+1]),
            .pipe_free_o (pipe_free[r+1])
        );
        assign match_acc[r+1] = match_acc[r] | m;
    end

    // Merge: OR-combine the per-pair matches into the index fields.
    always_comb begin
        pipe_val_o  = '0;
        pipe_lane_o = '0;
        lane_hit_o  = '0;
        lane_pipe_o = '0;
        for (int l = 0; l < L; l++) begin
            for (int p = 0; p < P; p++) begin
                if (match_acc[ITERS][l*P+p]) begin
                    pipe_val_o[p]                = 1'b1;
                    pipe_lane_o[p*LIDX +: LIDX] |= LIDX'(l);
                    lane_hit_o[l]                = 1'b1;
                    lane_pipe_o[l*PIDX +: PIDX] |= PIDX'(p);
                end
            end
        end
    end

    always_comb begin
        for (int p = 0; p < P; p++) begin
            if (pipe_val_o[p]) begin
                assert_pair_eligible_R1: assert (elig[int'(pipe_lane_o[p*LIDX +: LIDX])*P + p])
                    else $error("pipe matched to an ineligible lane");
                assert_bypass_ready_R2: assert (!pipe_bypass_i[p] ||
                        (src_a_rdy_i[pipe_lane_o[p*LIDX +: LIDX]] && src_b_rdy_i[pipe_lane_o[p*LIDX +: LIDX]]))
                    else $error("bypass pipe matched to a lane with pending sources");
            end
        end
        for (int l = 0; l < L; l++) begin
            if (lane_hit_o[l]) begin
                assert_back_link_R8: assert (pipe_val_o[lane_pipe_o[l*PIDX +: PIDX]] &&
                        int'(pipe_lane_o[int'(lane_pipe_o[l*PIDX +: PIDX])*LIDX +: LIDX]) == l)
                    else $error("lane and pipe outputs disagree");
            end
        end
        assert_one_to_one_R6: assert ($countones(pipe_val_o) == $countones(lane_hit_o))
            else $error("matched lane and pipe counts differ");
        if (ITERS >= MINLP) begin
            for (int l = 0; l < L; l++) begin
                for (int p = 0; p < P; p++) begin
                    assert_maximal_R7: assert (!(elig[l*P+p] && !lane_hit_o[l] && !pipe_val_o[p]))
                        else $error("eligible pair left unmatched");
                end
            end
        end
    end
endmodule

// File: tb/test_lane_pipe_matcher.sv
module test_lane_pipe_matcher;
    localparam int L = 4, P = 3, SEQW = 8, SLOTW = 4;
    localparam int LIDX = 2, PIDX = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    // Behavioural stimulus
    bit         cmp   [L][P];
    bit         lval  [L];
    int         lseq  [L];
    bit         sa    [L], sb [L];
    bit         qr    [P];
    int         qs    [P];
    bit         byp   [P];
    int         old_s;

    logic [L*P-1:0]     compat;
    logic [L-1:0]       lane_valid, src_a, src_b, lane_hit;
    logic [L*SEQW-1:0]  lane_seq;
    logic [P-1:0]       q_ready, bypass, pipe_val;
    logic [P*SLOTW-1:0] q_slots;
    logic [SEQW-1:0]    oldest;
    logic [P*LIDX-1:0]  pipe_lane;
    logic [L*PIDX-1:0]  lane_pipe;

    always_comb begin
        for (int l = 0; l < L; l++) begin
            for (int p = 0; p < P; p++) compat[l*P+p] = cmp[l][p];
            lane_valid[l] = lval[l];
            lane_seq[l*SEQW +: SEQW] = SEQW'(lseq[l]);
            src_a[l] = sa[l];
            src_b[l] = sb[l];
        end
        for (int p = 0; p < P; p++) begin
            q_ready[p] = qr[p];
            q_slots[p*SLOTW +: SLOTW] = SLOTW'(qs[p]);
            bypass[p] = byp[p];
        end
        oldest = SEQW'(old_s);
    end

    lane_pipe_matcher #(.L(L), .P(P), .SEQW(SEQW), .SLOTW(SLOTW)) i_lane_pipe_matcher (
        .compat_i(compat), .lane_valid_i(lane_valid), .lane_seq_i(lane_seq),
        .src_a_rdy_i(src_a), .src_b_rdy_i(src_b), .q_ready_i(q_ready),
        .q_slots_i(q_slots), .pipe_bypass_i(bypass), .oldest_seq_i(oldest),
        .pipe_val_o(pipe_val), .pipe_lane_o(pipe_lane),
        .lane_hit_o(lane_hit), .lane_pipe_o(lane_pipe)
    );

    // Reference model
    int e_plane [P];
    int e_lpipe [L];

    function automatic bit older(int a, int b);
        return (a < b) ^ (a < old_s) ^ (b < old_s);
    endfunction

    function automatic bit ok(int l, int p);
        return cmp[l][p] && lval[l] && qr[p] && qs[p] > 0 && (!byp[p] || (sa[l] && sb[l]));
    endfunction

    task automatic model();
        int g [P];
        for (int p = 0; p < P; p++) e_plane[p] = -1;
        for (int l = 0; l < L; l++) e_lpipe[l] = -1;
        for (int r = 0; r < L; r++) begin
            for (int p = 0; p < P; p++) begin
                g[p] = -1;
                if (e_plane[p] >= 0) continue;
                for (int l = 0; l < L; l++)
                    if (e_lpipe[l] < 0 && ok(l, p) && (g[p] < 0 || older(lseq[l], lseq[g[p]])))
                        g[p] = l;
            end
            for (int l = 0; l < L; l++) begin
                int b = -1;
                for (int p = 0; p < P; p++)
                    if (g[p] == l && (b < 0 || qs[p] > qs[b])) b = p;
                if (b >= 0) begin
                    e_lpipe[l] = b;
                    e_plane[b] = l;
                end
            end
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic go(string tag);
        @(negedge clk);
        model();
        for (int p = 0; p < P; p++) begin
            chk(tag, $sformatf("pipe%0d valid", p), int'(pipe_val[p]), int'(e_plane[p] >= 0));
            if (e_plane[p] >= 0)
                chk(tag, $sformatf("pipe%0d lane", p), int'(pipe_lane[p*LIDX +: LIDX]), e_plane[p]);
        end
        for (int l = 0; l < L; l++) begin
            chk(tag, $sformatf("lane%0d hit", l), int'(lane_hit[l]), int'(e_lpipe[l] >= 0));
            if (e_lpipe[l] >= 0)
                chk(tag, $sformatf("lane%0d pipe", l), int'(lane_pipe[l*PIDX +: PIDX]), e_lpipe[l]);
        end
    endtask

    task automatic clear();
        for (int l = 0; l < L; l++) begin
            for (int p = 0; p < P; p++) cmp[l][p] = 0;
            lval[l] = 0; lseq[l] = 0; sa[l] = 0; sb[l] = 0;
        end
        for (int p = 0; p < P; p++) begin qr[p] = 0; qs[p] = 0; byp[p] = 0; end
        old_s = 0;
    endtask

    // A single lane 0 eligible on pipe 0
    task automatic one_pair();
        clear();
        cmp[0][0] = 1; lval[0] = 1; qr[0] = 1; qs[0] = 5;
    endtask

    // Direct checks of specific values
    task automatic exact(string tag, int pipe, int lane);
        @(negedge clk);
        n_run++;
        if (!(pipe_val[pipe] && int'(pipe_lane[pipe*LIDX +: LIDX]) == lane)) begin
            n_fail++;
            $display("FAIL %s: pipe%0d actual val=%0d lane=%0d expected lane %0d",
                     tag, pipe, pipe_val[pipe], pipe_lane[pipe*LIDX +: LIDX], lane);
        end
    endtask

    initial begin
        rst_n = 0;
        clear();
        repeat (3) @(posedge clk);
        rst_n = 1;

        // R9: nothing eligible, every flag low
        @(posedge clk); go("R9 idle");

        // R1: each of the four conditions removed in turn
        @(posedge clk); one_pair(); go("R1 all met");
        exact("R1 all met", 0, 0);
        @(posedge clk); one_pair(); cmp[0][0] = 0; go("R1 no compat");
        @(posedge clk); one_pair(); lval[0] = 0;   go("R1 lane invalid");
        @(posedge clk); one_pair(); qr[0] = 0;     go("R1 queue busy");
        @(posedge clk); one_pair(); qs[0] = 0;     go("R1 no slots");

        // R2: bypass pipe needs both operands
        @(posedge clk); one_pair(); byp[0] = 1; sa[0] = 1; go("R2 one src pending");
        @(posedge clk); one_pair(); byp[0] = 1; sa[0] = 1; sb[0] = 1; go("R2 srcs ready");
        exact("R2 srcs ready", 0, 0);

        // R3: wrap-around age; lane1 seq 252 is older than lane0 seq 2 with oldest 250
        @(posedge clk); one_pair(); old_s = 250; lseq[0] = 2;
        cmp[1][0] = 1; lval[1] = 1; lseq[1] = 252; go("R3 wrap age");
        exact("R3 wrap age", 0, 1);

        // R4: equal age goes to the lower lane
        @(posedge clk); clear(); qr[0] = 1; qs[0] = 3;
        cmp[2][0] = 1; lval[2] = 1; lseq[2] = 9;
        cmp[3][0] = 1; lval[3] = 1; lseq[3] = 9; go("R4 age tie");
        exact("R4 age tie", 0, 2);

        // R5: slots 3,7,7 -> pipe 1
        @(posedge clk); clear(); lval[0] = 1;
        for (int p = 0; p < P; p++) begin cmp[0][p] = 1; qr[p] = 1; end
        qs[0] = 3; qs[1] = 7; qs[2] = 7; go("R5 slot pick");
        exact("R5 slot pick", 1, 0);

        // R6: lane0 takes pipe0 in round 1; lane1 gets pipe1 only in round 2
        @(posedge clk); clear(); qr[0] = 1; qr[1] = 1; qs[0] = 9; qs[1] = 2;
        lval[0] = 1; lseq[0] = 3; cmp[0][0] = 1; cmp[0][1] = 1;
        lval[1] = 1; lseq[1] = 5; cmp[1][0] = 1; cmp[1][1] = 1; go("R6 second round");
        exact("R6 second round", 1, 1);

        // R7 / R8: random patterns against the model
        for (int k = 0; k < 400; k++) begin
            @(posedge clk);
            old_s = $urandom_range(0, 255);
            for (int l = 0; l < L; l++) begin
                for (int p = 0; p < P; p++) cmp[l][p] = ($urandom_range(0, 2) != 0);
                lval[l] = ($urandom_range(0, 4) != 0);
                lseq[l] = (k % 3 == 0) ? $urandom_range(0, 3) : $urandom_range(0, 255);
                sa[l] = $urandom_range(0, 1); sb[l] = $urandom_range(0, 1);
            end
            for (int p = 0; p < P; p++) begin
                qr[p] = ($urandom_range(0, 5) != 0);
                qs[p] = (k % 2 == 0) ? $urandom_range(0, 2) : $urandom_range(0, 15);
                byp[p] = ($urandom_range(0, 3) == 0);
            end
            go((k % 2 == 0) ? "R7 random" : "R8 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule